// File: doc/BRIEF.md
# Serial Command Register Port

This block is a slave-side serial port that gives an external controller read and write access to a bank of eight command registers. Four wires connect it: an active-low select, a serial clock, a data input and a data output. The data output is driven only while read bits are being sent. At all other times it is high impedance, so the data input and data output can be joined into one bidirectional line.

The block samples the serial wires with its own system clock. It passes them through a short synchronizer and acts on the detected serial clock edges. Every frame is 16 serial clocks long and has four parts, in this order:

1. A direction flag.
2. A three-bit register address.
3. A four-clock idle gap.
4. A data field. A read sends back 5 bits; a write takes in 8 bits.

Raising the select line before the frame completes abandons it. The register contents are brought out in parallel for the logic the registers control.

The frame sequencer has six states:

- `ST_IDLE`: the select line is high.
- `ST_HEADER`: the flag and address are being taken in.
- `ST_GAP`: the idle clocks are passing.
- `ST_READ`: read bits are being sent.
- `ST_WRITE`: write bits are being taken in.
- `ST_DONE`: the frame is over and the block waits for the select line to rise.

The transitions are:

- `ST_IDLE` to `ST_HEADER` when the select line is seen low.
- `ST_HEADER` to `ST_GAP` on the 4th serial clock rise.
- `ST_GAP` to `ST_READ` or `ST_WRITE` on the 8th rise, according to the flag.
- `ST_READ` to `ST_DONE` on the falling edge after the 5th bit has been sent.
- `ST_WRITE` to `ST_DONE` on the 16th rise.
- Any state to `ST_IDLE` when the select line is seen high.

Top module: `ser_cmd_port`

## Requirements
- R1: After reset, `sdo_oe` is 0, `sdo` is high impedance and all eight registers on `cmd_regs` read 0. Register k occupies `cmd_regs[8k+7:8k]`.
- R2: With `cs_n` low, the value on `sdi` at the 1st `sclk` rise sets the direction: 1 means read, 0 means write. The values at rises 2, 3 and 4 form the register address, least significant bit first.
- R3: The `sdi` values at rises 5 to 8 have no effect. `sdo_oe` stays 0 from the start of a frame until the falling edge that follows rise 8.
- R4: In a read frame, the block starts driving on the falling edge after rise 8. It presents bits [4:0] of the addressed register least significant bit first, one bit per serial clock, so that each is valid at rises 9 to 13.
- R5: In a read frame, `sdo_oe` returns to 0 on the falling edge after rise 13 and stays 0 for the rest of the frame. A read leaves every register unchanged.
- R6: In a write frame, the `sdi` values at rises 9 to 16 form an 8-bit word, least significant bit first. The whole word is stored in the addressed register and no other register changes.
- R7: A register changes only after the 8th data bit has been captured at rise 16. A write frame ended before rise 16 leaves all registers unchanged.
- R8: Raising `cs_n` before a frame completes aborts it. `sdo_oe` falls within 4 system clocks, and the next frame is decoded from its own 1st rise.
- R9: Serial clock rises after the 16th, while `cs_n` is still low, change neither the registers nor `sdo_oe`.
- R10: `sdo` and `sclk` are not driven while `cs_n` is high. `sclk` needs no activity between frames. Each `sclk` level must last at least 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial wires |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select from the controller |
| sclk | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data in, sampled at `sclk` rises |
| sdo | output | 1 | Serial data out, high impedance unless sending read bits |
| sdo_oe | output | 1 | High while `sdo` is being driven |
| cmd_regs | output | 64 | Contents of the eight 8-bit command registers, register k at bits [8k+7:8k] |

## Verification
A wrong bit counter or state shows first on `sdo_oe`. The enable either rises during the header or gap, or arrives one serial clock off. That makes the read bits appear shifted by one position within a single frame. A bad address or shift register shows at the next write as the wrong register changing on `cmd_regs`, a few system clocks after rise 16. A missing abort path shows either as `sdo_oe` still high 4 clocks after `cs_n` rises, or as the following frame being decoded out of step.

// File: rtl/ser_cmd_pkg.sv
package ser_cmd_pkg;
    localparam int ADDR_W     = 3;
    localparam int NREG       = 1 << ADDR_W;
    localparam int REG_W      = 8;
    localparam int RD_W       = 5;
    localparam int GAP_CLKS   = 4;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int DATA_START = HDR_BITS + GAP_CLKS;
    localparam int FRAME_CLKS = DATA_START + REG_W;
    localparam int CNT_W      = $clog2(FRAME_CLKS + 1);
    localparam int IDX_W      = $clog2(RD_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_GAP,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } ser_state_e;
endpackage

// File: rtl/ser_cmd_sync.sv
module ser_cmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic sdi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic sdi_s
);
    logic [STAGES-1:0] sclk_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] sdi_p;
    logic              sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= '0;
            cs_p   <= '1;
            sdi_p  <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
            cs_p   <= {cs_p[STAGES-2:0], cs_n_i};
            sdi_p  <= {sdi_p[STAGES-2:0], sdi_i};
            sclk_d <= sclk_p[STAGES-1];
        end
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_d;
    assign cs_act    = ~cs_p[STAGES-1];
    assign sdi_s     = sdi_p[STAGES-1];
endmodule

// File: rtl/ser_cmd_bank.sv
module ser_cmd_bank
    import ser_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wr_data,
    output logic [RD_W-1:0]       rd_data,
    output logic [NREG*REG_W-1:0] regs_flat
);
    logic [REG_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && addr == ADDR_W'(g)) begin
                regs[g] <= wr_data;
            end
        end
        assign regs_flat[g*REG_W +: REG_W] = regs[g];
    end

    assign rd_data = regs[addr][RD_W-1:0];

    // Contents move only on a committed write strobe.
    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/ser_cmd_fsm.sv
module ser_cmd_fsm
    import ser_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_act,
    input  logic              sdi_s,
    input  logic [RD_W-1:0]   rd_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_data,
    output logic              sdo_q,
    output logic              sdo_oe
);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(DATA_START - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_CLKS - 1);
    localparam logic [CNT_W-1:0] FRAME_END  = CNT_W'(FRAME_CLKS);
    localparam logic [IDX_W-1:0] RD_END     = IDX_W'(RD_W);

    ser_state_e       st, nxt;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] rd_idx;
    logic             rw_q;
    logic [RD_W-1:0]  rd_word;
    logic [REG_W-2:0] wsh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (!cs_act) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:   nxt = ST_HEADER;
                ST_HEADER: if (sclk_rise && cnt == HDR_LAST) nxt = ST_GAP;
                ST_GAP:    if (sclk_rise && cnt == GAP_LAST) nxt = rw_q ? ST_READ : ST_WRITE;
                ST_READ:   if (sclk_fall && rd_idx == RD_END) nxt = ST_DONE;
                ST_WRITE:  if (sclk_rise && cnt == FRAME_LAST) nxt = ST_DONE;
                ST_DONE:   nxt = ST_DONE;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rd_idx  <= '0;
            rw_q    <= 1'b0;
            addr_q  <= '0;
            rd_word <= '0;
            wsh     <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            sdo_q   <= 1'b0;
            sdo_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (!cs_act || st == ST_IDLE) begin
                cnt    <= '0;
                rd_idx <= '0;
                sdo_oe <= 1'b0;
            end else begin
                if (sclk_rise && cnt != FRAME_END) cnt <= cnt + 1'b1;
                unique case (st)
                    ST_HEADER: if (sclk_rise) begin
                        if (cnt == '0) rw_q <= sdi_s;
                        else           addr_q <= {sdi_s, addr_q[ADDR_W-1:1]};
                    end
                    ST_GAP: if (sclk_rise && cnt == GAP_LAST) rd_word <= rd_data;
                    ST_READ: if (sclk_fall) begin
                        if (rd_idx != RD_END) begin
                            sdo_oe <= 1'b1;
                            sdo_q  <= rd_word[rd_idx];
                            rd_idx <= rd_idx + 1'b1;
                        end else begin
                            sdo_oe <= 1'b0;
                        end
                    end
                    ST_WRITE: if (sclk_rise) begin
                        wsh <= {sdi_s, wsh[REG_W-2:1]};
                        if (cnt == FRAME_LAST) begin
                            wr_en   <= 1'b1;
                            wr_data <= {sdi_s, wsh};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_oe_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> st == ST_READ);
    assert_abort_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!sdo_oe && st == ST_IDLE));
    assert_hdr_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_HEADER |-> cnt < CNT_W'(HDR_BITS));
    assert_commit_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st == ST_DONE && cnt == FRAME_END));
    assert_read_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx <= RD_END);
endmodule

// File: rtl/ser_cmd_port.sv
module ser_cmd_port
    import ser_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  sdi,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic [NREG*REG_W-1:0] cmd_regs
);
    logic              sclk_rise, sclk_fall, cs_act, sdi_s;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [REG_W-1:0]  wr_data;
    logic [RD_W-1:0]   rd_data;
    logic              sdo_q;

    ser_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .cs_n_i    (cs_n),
        .sdi_i     (sdi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .sdi_s     (sdi_s)
    );

    ser_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .sdi_s     (sdi_s),
        .rd_data   (rd_data),
        .addr_q    (addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sdo_q     (sdo_q),
        .sdo_oe    (sdo_oe)
    );

    ser_cmd_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .regs_flat (cmd_regs)
    );

    assign sdo = sdo_oe ? sdo_q : 1'bz;

    // The output is never enabled while the controller is deselected (R10),
    // allowing for the synchronizer delay plus one cycle.
    assert_deselect_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);
endmodule

// File: tb/test_ser_cmd_port.sv
module test_ser_cmd_port;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    wire         sdo;
    logic        sdo_oe;
    logic [63:0] cmd_regs;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_regs [8];

    logic [4:0] rd_got;
    bit         rd_miss, oe_early, oe_late, oe_after;

    always #5 clk = ~clk;

    ser_cmd_port i_ser_cmd_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sdi      (sdi),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .cmd_regs (cmd_regs)
    );

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        for (int k = 0; k < 8; k++)
            chk(cmd_regs[k*8 +: 8] == exp_regs[k], req, $sformatf("reg %0d", k),
                cmd_regs[k*8 +: 8], exp_regs[k]);
    endtask

    // One frame of nrise serial clocks; results left in rd_got / flags.
    task automatic frame(input bit rw, input logic [2:0] a, input logic [7:0] wd,
                         input int nrise, input bit gap_val);
        rd_got = '0; rd_miss = 0; oe_early = 0; oe_late = 0; oe_after = 0;
        cs_n = 1'b0;
        sclk = 1'b0;
        for (int i = 1; i <= nrise; i++) begin
            if (i == 1)       sdi = rw;
            else if (i <= 4)  sdi = a[i-2];
            else if (i <= 8)  sdi = gap_val;
            else if (i <= 16) sdi = rw ? 1'b0 : wd[i-9];
            else              sdi = ~wd[0];
            wait_cyc(HALF - 1);
            if (i <= 8 && sdo_oe) oe_early = 1;
            if (i >= 9 && i <= 13) begin
                if (!sdo_oe) rd_miss = 1;
                rd_got[i-9] = sdo;
            end
            if (i >= 14 && sdo_oe) oe_late = 1;
            wait_cyc(1);
            sclk = 1'b1;
            wait_cyc(HALF);
            sclk = 1'b0;
        end
        wait_cyc(HALF - 1);
        if (nrise >= 13 && sdo_oe) oe_late = 1;
        cs_n = 1'b1;
        sclk = 1'b1;
        wait_cyc(4);
        oe_after = sdo_oe;
        wait_cyc(26);
    endtask

    task automatic test_reset;
        chk(sdo_oe == 1'b0, "R1", "sdo_oe after reset", sdo_oe, 0);
        chk(cmd_regs == '0, "R1", "registers after reset", cmd_regs, 0);
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d, input string req);
        frame(1'b0, a, d, 16, 1'b0);
        exp_regs[a] = d;
        chk(!oe_early && !oe_late, req, "sdo_oe during write", sdo_oe, 0);
        check_bank(req);
    endtask

    task automatic do_read(input logic [2:0] a, input string req);
        frame(1'b1, a, 8'h00, 16, 1'b0);
        chk(!rd_miss, "R4", "sdo_oe during read bits", rd_miss, 0);
        chk(rd_got == exp_regs[a][4:0], req, $sformatf("read reg %0d", a),
            rd_got, exp_regs[a][4:0]);
        chk(!oe_early, "R3", "sdo_oe before data field", oe_early, 0);
        chk(!oe_late, "R5", "sdo_oe after 5th bit", oe_late, 0);
        check_bank("R5");
    endtask

    task automatic test_writes;
        do_write(3'd3, 8'hA5, "R6");
        do_write(3'd5, 8'h3C, "R2");
        do_write(3'd6, 8'hE7, "R2");
        do_write(3'd1, 8'h80, "R6");
        do_write(3'd0, 8'h01, "R6");
        do_write(3'd7, 8'hFF, "R6");
    endtask

    task automatic test_reads;
        do_read(3'd3, "R4");
        do_read(3'd5, "R2");
        do_read(3'd6, "R4");
        do_read(3'd7, "R4");
        do_read(3'd2, "R4");
    endtask

    task automatic test_gap_ignored;
        frame(1'b0, 3'd2, 8'h5A, 16, 1'b1);
        exp_regs[2] = 8'h5A;
        check_bank("R3");
        frame(1'b1, 3'd2, 8'h00, 16, 1'b1);
        chk(rd_got == 5'h1A, "R3", "read after gap ones", rd_got, 5'h1A);
    endtask

    task automatic test_abort;
        frame(1'b0, 3'd4, 8'hC3, 15, 1'b0);
        check_bank("R7");
        frame(1'b0, 3'd4, 8'h99, 11, 1'b0);
        check_bank("R7");
        frame(1'b1, 3'd3, 8'h00, 10, 1'b0);
        chk(!oe_after, "R8", "sdo_oe 4 clocks after abort", oe_after, 0);
        check_bank("R8");
        do_write(3'd4, 8'h6D, "R8");
        do_read(3'd4, "R8");
    endtask

    task automatic test_extra_clocks;
        frame(1'b0, 3'd1, 8'h42, 19, 1'b0);
        exp_regs[1] = 8'h42;
        check_bank("R9");
        chk(!oe_late && !oe_after, "R9", "sdo_oe with extra clocks", oe_late, 0);
        frame(1'b1, 3'd1, 8'h00, 19, 1'b0);
        chk(rd_got == 5'h02, "R9", "read with extra clocks", rd_got, 5'h02);
        chk(!oe_late, "R9", "sdo_oe after frame end", oe_late, 0);
    endtask

    task automatic test_deselect;
        cs_n = 1'b1;
        sdi = 1'b1;
        for (int i = 0; i < 6; i++) begin
            sclk = ~sclk;
            wait_cyc(HALF);
            chk(!sdo_oe, "R10", "sdo_oe while deselected", sdo_oe, 0);
        end
        sclk = 1'b1;
        check_bank("R10");
        wait_cyc(20);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) exp_regs[k] = '0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(10);
        test_reset();
        test_writes();
        test_reads();
        test_gap_ignored();
        test_abort();
        test_extra_clocks();
        test_deselect();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule